// File: doc/BRIEF.md
# Debug Data Address Compare Qualifier

This block decides, for every storage instruction that a core presents to it, whether a data address compare debug event of the read kind or the write kind should be raised. It also decides whether the stricter data value compare event fires. Each instruction arrives as one strobed record. The record holds a four-bit class code, the effective address, the caching-inhibited and translation-exception flags, the reservation flag used by conditional stores, the string byte count and the data value. The block first sorts the class into a read access, a write access or no access. This step applies the quirks of cache-maintenance, touch, conditional and string instructions. It then compares the address against a set of software-programmed compare registers.

Each compare register carries an address, a don't-care mask, separate enables for read-type and write-type accesses, and a data compare with a per-byte enable. The three event outputs are registered. Each is a one-cycle pulse that follows the strobe by one clock. The core's exception and debug-interrupt logic uses these pulses.

Top module: `dbg_dac_qual`

## Requirements
- R1: After a synchronous active-low reset, and in any cycle that follows a cycle with `in_valid` low, `ev_rd`, `ev_wr` and `ev_dvc` are all 0.
- R2: A load (class 0) gives `ev_rd`=1 and a store (class 1) gives `ev_wr`=1 on the clock after the strobe. This holds only when some compare register `i` has `(in_ea ^ cmp_addr[i]) & ~cmp_mask[i]` equal to zero and has its read enable (`cmp_rd_en[i]`) or write enable (`cmp_wr_en[i]`) set for that access type. `ev_rd` and `ev_wr` are never high together.
- R3: Block-clean (class 2) and block-flush (class 3) are treated as write accesses and can raise `ev_wr`, never `ev_rd`.
- R4: Data touch (class 4) and instruction touch (class 5) are read accesses. Neither raises an event when `in_ci` or `in_xlate_exc` is 1.
- R5: Block-allocate (class 6), whole-cache invalidate (class 8), cache read-by-index (class 9) and the unused codes 14 and 15 never raise any event.
- R6: Instruction-cache block invalidate (class 7) is a read access and can raise `ev_rd`.
- R7: A conditional store (class 10) raises `ev_wr` only when `in_resv` is 1.
- R8: Load-string (class 11) is a read and store-string (class 12) is a write. Both raise no event when `in_len` is 0.
- R9: `ev_dvc` fires only for classes 0, 1 and 13. It needs a register `i` that matches the address with the access type enabled, has `dvc_en[i]` set, and agrees with `in_data` on every byte `k` whose `dvc_byte_en[i][k]` is 1. Byte `k` is `in_data[8k+7:8k]`. An all-zero byte enable matches any data.
- R10: Block-zero (class 13) is a write access and can raise `ev_wr`.
- R11: Address bits set in `cmp_mask[i]` are ignored in the compare. Caching-inhibit, exception, reservation and length flags have no effect on classes other than those named above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction record strobe |
| in_class | input | 4 | Instruction class code |
| in_ea | input | ADDR_W | Effective address |
| in_ci | input | 1 | Target is caching-inhibited |
| in_xlate_exc | input | 1 | Access would take a storage or TLB-miss exception |
| in_resv | input | 1 | Reservation held for conditional store |
| in_len | input | LEN_W | String byte count |
| in_data | input | DATA_W | Data value accessed |
| cmp_addr | input | NUM_CMP x ADDR_W | Compare addresses |
| cmp_mask | input | NUM_CMP x ADDR_W | Address don't-care masks |
| cmp_rd_en | input | NUM_CMP | Per-register read-type enable |
| cmp_wr_en | input | NUM_CMP | Per-register write-type enable |
| dvc_en | input | NUM_CMP | Per-register data compare enable |
| dvc_value | input | NUM_CMP x DATA_W | Data compare values |
| dvc_byte_en | input | NUM_CMP x DATA_W/8 | Per-byte data compare enables |
| ev_rd | output | 1 | Read address compare event pulse |
| ev_wr | output | 1 | Write address compare event pulse |
| ev_dvc | output | 1 | Data value compare event pulse |

## Verification
The bench sweeps every class code against every combination of the caching-inhibited, exception and reservation flags and a zero or non-zero string length. It does this at an exact-hit address, a mask-hit address and a miss address, with matching and mismatching data, under two register configurations. A design that treated block-clean or block-flush as loads would pulse `ev_rd` where `ev_wr` is expected. A design that ignored the touch no-op rule, the reservation or the zero length would raise spurious events. A design that checked data against a register other than the one that matched the address would raise `ev_dvc` on a data match alone. Partial byte enables and read-only registers probe the per-byte and per-type gating.

// File: rtl/dbg_dac_pkg.sv
// Shared types for the debug address compare qualifier.
// Assumes a 4-bit class code supplied by the core's decode stage.
package dbg_dac_pkg;

    typedef enum logic [3:0] {
        OP_LOAD          = 4'd0,
        OP_STORE         = 4'd1,
        OP_BLK_CLEAN     = 4'd2,
        OP_BLK_FLUSH     = 4'd3,
        OP_DTOUCH        = 4'd4,
        OP_ITOUCH        = 4'd5,
        OP_BLK_ALLOC     = 4'd6,
        OP_IBLK_INVAL    = 4'd7,
        OP_CACHE_INV_ALL = 4'd8,
        OP_CACHE_IDX_RD  = 4'd9,
        OP_STORE_COND    = 4'd10,
        OP_LOAD_STR      = 4'd11,
        OP_STORE_STR     = 4'd12,
        OP_BLK_ZERO      = 4'd13,
        OP_RSVD14        = 4'd14,
        OP_RSVD15        = 4'd15
    } op_class_e;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;    // access type seen by the address compare
        logic      dvc_ok;  // class may take part in a data compare
    } acc_info_t;

endpackage

// File: rtl/dbg_dac_classify.sv
// Maps an instruction class plus its qualifying flags onto the access type
// used by the debug address compare, and flags the classes that may raise
// a data value compare. Purely combinational; assumes flags are valid
// together with the class code.
module dbg_dac_classify
    import dbg_dac_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  logic [3:0]       op,
    input  logic             ci,
    input  logic             xlate_exc,
    input  logic             resv,
    input  logic [LEN_W-1:0] len,
    output acc_info_t        info
);

    logic len_zero;
    assign len_zero = (len == '0);

    // Decode class into read, write or no access, applying the suppression rules.
    always_comb begin
        info = '{kind: ACC_NONE, dvc_ok: 1'b0};
        unique case (op_class_e'(op))
            OP_LOAD:       info = '{kind: ACC_READ,  dvc_ok: 1'b1};
            OP_STORE:      info = '{kind: ACC_WRITE, dvc_ok: 1'b1};
            OP_BLK_ZERO:   info = '{kind: ACC_WRITE, dvc_ok: 1'b1};
            OP_BLK_CLEAN,
            OP_BLK_FLUSH:  info.kind = ACC_WRITE;
            OP_DTOUCH,
            OP_ITOUCH:     info.kind = (ci || xlate_exc) ? ACC_NONE : ACC_READ;
            OP_IBLK_INVAL: info.kind = ACC_READ;
            OP_STORE_COND: info.kind = resv ? ACC_WRITE : ACC_NONE;
            OP_LOAD_STR:   info.kind = len_zero ? ACC_NONE : ACC_READ;
            OP_STORE_STR:  info.kind = len_zero ? ACC_NONE : ACC_WRITE;
            default:       info.kind = ACC_NONE;
        endcase
    end

endmodule

// File: rtl/dbg_dac_match.sv
// Per-register masked address compare and byte-enabled data compare.
// One compare slice is generated per register; assumes DATA_W is a
// multiple of 8.
module dbg_dac_match #(
    parameter int NUM_CMP = 2,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32
) (
    input  logic [ADDR_W-1:0]                 ea,
    input  logic [DATA_W-1:0]                 data,
    input  logic [NUM_CMP-1:0][ADDR_W-1:0]    cmp_addr,
    input  logic [NUM_CMP-1:0][ADDR_W-1:0]    cmp_mask,
    input  logic [NUM_CMP-1:0][DATA_W-1:0]    dvc_value,
    input  logic [NUM_CMP-1:0][DATA_W/8-1:0]  dvc_byte_en,
    output logic [NUM_CMP-1:0]                addr_hit,
    output logic [NUM_CMP-1:0]                data_hit
);

    localparam int NB = DATA_W / 8;

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_reg
        logic [NB-1:0] byte_ok;

        // Address compare with don't-care bits removed.
        assign addr_hit[i] = (((ea ^ cmp_addr[i]) & ~cmp_mask[i]) == '0);

        for (genvar k = 0; k < NB; k++) begin : g_byte
            // A byte agrees when disabled or equal.
            assign byte_ok[k] = !dvc_byte_en[i][k] ||
                                (data[8*k +: 8] == dvc_value[i][8*k +: 8]);
        end

        assign data_hit[i] = &byte_ok;
    end

endmodule

// File: rtl/dbg_dac_qual.sv
// Top of the debug address compare qualifier. Classifies each strobed
// instruction, compares it against the programmed registers and registers
// the read, write and data value compare event pulses (one clock latency).
// Assumes compare registers are stable while instructions are strobed.
module dbg_dac_qual
    import dbg_dac_pkg::*;
#(
    parameter int NUM_CMP = 2,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int LEN_W   = 7
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic [3:0]                        in_class,
    input  logic [ADDR_W-1:0]                 in_ea,
    input  logic                              in_ci,
    input  logic                              in_xlate_exc,
    input  logic                              in_resv,
    input  logic [LEN_W-1:0]                  in_len,
    input  logic [DATA_W-1:0]                 in_data,
    input  logic [NUM_CMP-1:0][ADDR_W-1:0]    cmp_addr,
    input  logic [NUM_CMP-1:0][ADDR_W-1:0]    cmp_mask,
    input  logic [NUM_CMP-1:0]                cmp_rd_en,
    input  logic [NUM_CMP-1:0]                cmp_wr_en,
    input  logic [NUM_CMP-1:0]                dvc_en,
    input  logic [NUM_CMP-1:0][DATA_W-1:0]    dvc_value,
    input  logic [NUM_CMP-1:0][DATA_W/8-1:0]  dvc_byte_en,
    output logic                              ev_rd,
    output logic                              ev_wr,
    output logic                              ev_dvc
);

    acc_info_t          info;
    logic [NUM_CMP-1:0] addr_hit;
    logic [NUM_CMP-1:0] data_hit;
    logic [NUM_CMP-1:0] type_en;
    logic [NUM_CMP-1:0] dac_sel;
    logic               rd_nxt, wr_nxt, dvc_nxt;

    dbg_dac_classify #(.LEN_W(LEN_W)) u_cls (
        .op        (in_class),
        .ci        (in_ci),
        .xlate_exc (in_xlate_exc),
        .resv      (in_resv),
        .len       (in_len),
        .info      (info)
    );

    dbg_dac_match #(
        .NUM_CMP (NUM_CMP),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_match (
        .ea          (in_ea),
        .data        (in_data),
        .cmp_addr    (cmp_addr),
        .cmp_mask    (cmp_mask),
        .dvc_value   (dvc_value),
        .dvc_byte_en (dvc_byte_en),
        .addr_hit    (addr_hit),
        .data_hit    (data_hit)
    );

    // Pick the enables that apply to this access type and combine with address hits.
    always_comb begin
        unique case (info.kind)
            ACC_READ:  type_en = cmp_rd_en;
            ACC_WRITE: type_en = cmp_wr_en;
            default:   type_en = '0;
        endcase
        dac_sel = addr_hit & type_en;
        rd_nxt  = in_valid && (info.kind == ACC_READ)  && (|dac_sel);
        wr_nxt  = in_valid && (info.kind == ACC_WRITE) && (|dac_sel);
        dvc_nxt = in_valid && info.dvc_ok && (|(dac_sel & dvc_en & data_hit));
    end

    // Register the event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_rd  <= 1'b0;
            ev_wr  <= 1'b0;
            ev_dvc <= 1'b0;
        end else begin
            ev_rd  <= rd_nxt;
            ev_wr  <= wr_nxt;
            ev_dvc <= dvc_nxt;
        end
    end

endmodule

// File: rtl/dbg_dac_qual_chk.sv
// Assertion checker for dbg_dac_qual, attached by bind. Observes only
// ports; each property relates a strobed input to the next-cycle outputs.
module dbg_dac_qual_chk #(
    parameter int LEN_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [3:0]       in_class,
    input logic             in_ci,
    input logic             in_xlate_exc,
    input logic             in_resv,
    input logic [LEN_W-1:0] in_len,
    input logic             ev_rd,
    input logic             ev_wr,
    input logic             ev_dvc
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!ev_rd && !ev_wr && !ev_dvc));                          // R1

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_rd && ev_wr));                                                   // R2

    AST_FLUSH_NO_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_class == 4'd2 || in_class == 4'd3)) |=> !ev_rd);      // R3

    AST_TOUCH_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_class == 4'd4 || in_class == 4'd5) && (in_ci || in_xlate_exc))
        |=> (!ev_rd && !ev_wr && !ev_dvc));                                   // R4

    AST_NOADDR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_class == 4'd6 || in_class == 4'd8 || in_class == 4'd9 ||
                      in_class == 4'd14 || in_class == 4'd15))
        |=> (!ev_rd && !ev_wr && !ev_dvc));                                   // R5

    AST_COND_NO_RESV: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 4'd10 && !in_resv) |=> (!ev_wr && !ev_rd));   // R7

    AST_STR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_class == 4'd11 || in_class == 4'd12) && in_len == '0)
        |=> (!ev_rd && !ev_wr && !ev_dvc));                                   // R8

    AST_DVC_NEEDS_DAC: assert property (@(posedge clk) disable iff (!rst_n)
        ev_dvc |-> (ev_rd || ev_wr));                                         // R9

    AST_DVC_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(in_class == 4'd0 || in_class == 4'd1 || in_class == 4'd13))
        |=> !ev_dvc);                                                         // R9

endmodule

bind dbg_dac_qual dbg_dac_qual_chk #(.LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_class     (in_class),
    .in_ci        (in_ci),
    .in_xlate_exc (in_xlate_exc),
    .in_resv      (in_resv),
    .in_len       (in_len),
    .ev_rd        (ev_rd),
    .ev_wr        (ev_wr),
    .ev_dvc       (ev_dvc)
);

// File: tb/sim_dbg_dac_qual.sv
// Self-checking bench: a behavioural reference model predicts the three
// event outputs for each strobe and compares them one clock later.
module sim_dbg_dac_qual;

    localparam int N  = 2;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int LW = 7;
    localparam int NB = DW / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [3:0] in_class = '0;
    logic [AW-1:0] in_ea = '0;
    logic in_ci = 1'b0, in_xlate_exc = 1'b0, in_resv = 1'b0;
    logic [LW-1:0] in_len = '0;
    logic [DW-1:0] in_data = '0;
    logic [N-1:0][AW-1:0] cmp_addr, cmp_mask;
    logic [N-1:0] cmp_rd_en, cmp_wr_en, dvc_en;
    logic [N-1:0][DW-1:0] dvc_value;
    logic [N-1:0][NB-1:0] dvc_byte_en;
    logic ev_rd, ev_wr, ev_dvc;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    dbg_dac_qual #(.NUM_CMP(N), .ADDR_W(AW), .DATA_W(DW), .LEN_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_ea(in_ea), .in_ci(in_ci), .in_xlate_exc(in_xlate_exc),
        .in_resv(in_resv), .in_len(in_len), .in_data(in_data),
        .cmp_addr(cmp_addr), .cmp_mask(cmp_mask), .cmp_rd_en(cmp_rd_en),
        .cmp_wr_en(cmp_wr_en), .dvc_en(dvc_en), .dvc_value(dvc_value),
        .dvc_byte_en(dvc_byte_en), .ev_rd(ev_rd), .ev_wr(ev_wr), .ev_dvc(ev_dvc)
    );

    task automatic check(input string req, input string what, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // Behavioural prediction: 0 none, 1 read, 2 write.
    task automatic predict(output bit rd, output bit wr, output bit dvc, output string tag);
        int kind = 0;
        bit dok = 0;
        int c = int'(in_class);
        rd = 0; wr = 0; dvc = 0;
        if (c == 0) begin kind = 1; dok = 1; tag = "R2"; end
        else if (c == 1) begin kind = 2; dok = 1; tag = "R2"; end
        else if (c == 2 || c == 3) begin kind = 2; tag = "R3"; end
        else if (c == 4 || c == 5) begin kind = (in_ci || in_xlate_exc) ? 0 : 1; tag = "R4"; end
        else if (c == 7) begin kind = 1; tag = "R6"; end
        else if (c == 10) begin kind = in_resv ? 2 : 0; tag = "R7"; end
        else if (c == 11) begin kind = (in_len == 0) ? 0 : 1; tag = "R8"; end
        else if (c == 12) begin kind = (in_len == 0) ? 0 : 2; tag = "R8"; end
        else if (c == 13) begin kind = 2; dok = 1; tag = "R10"; end
        else begin kind = 0; tag = "R5"; end
        if (!in_valid) begin kind = 0; tag = "R1"; end
        for (int i = 0; i < N; i++) begin
            bit ahit = 1, dhit = 1, en;
            for (int b = 0; b < AW; b++)
                if (!cmp_mask[i][b] && in_ea[b] != cmp_addr[i][b]) ahit = 0;
            for (int k = 0; k < NB; k++)
                if (dvc_byte_en[i][k] && in_data[8*k +: 8] != dvc_value[i][8*k +: 8]) dhit = 0;
            en = (kind == 1) ? cmp_rd_en[i] : (kind == 2) ? cmp_wr_en[i] : 1'b0;
            if (ahit && en) begin
                if (kind == 1) rd = 1;
                if (kind == 2) wr = 1;
                if (dok && dvc_en[i] && dhit) dvc = 1;
            end
        end
    endtask

    // Drive at negedge, predict, then compare shortly after the next posedge.
    task automatic step();
        bit erd, ewr, edvc;
        string tag;
        predict(erd, ewr, edvc, tag);
        @(posedge clk);
        #5;
        check(tag, "ev_rd", ev_rd, erd);
        check(tag, "ev_wr", ev_wr, ewr);
        check("R9", "ev_dvc", ev_dvc, edvc);
        @(negedge clk);
    endtask

    localparam logic [AW-1:0] A0 = 32'h0000_4A40;
    localparam logic [AW-1:0] A1 = 32'h0001_2300;
    localparam logic [DW-1:0] D0 = 32'hCAFE_0123;

    task automatic sweep();
        for (int c = 0; c < 16; c++)
        for (int f = 0; f < 16; f++)
        for (int a = 0; a < 3; a++)
        for (int d = 0; d < 2; d++) begin
            in_valid = 1; in_class = 4'(c);
            in_ci = f[0]; in_xlate_exc = f[1]; in_resv = f[2];
            in_len = f[3] ? 7'd5 : 7'd0;
            in_ea = (a == 0) ? A0 : (a == 1) ? (A1 | 32'h7) : 32'h0000_4A44;  // R11 mask hit
            in_data = d ? (D0 ^ 32'h00FF_0000) : D0;
            step();
        end
        in_valid = 0; in_class = 4'd0; in_ea = A0; in_data = D0;  // R1 idle with hit inputs
        repeat (4) step();
    endtask

    initial begin
        cmp_addr = '{A1, A0};
        cmp_mask = '{32'h0000_000F, 32'h0};
        cmp_rd_en = 2'b11; cmp_wr_en = 2'b01; dvc_en = 2'b01;
        dvc_value = '{D0, D0};
        dvc_byte_en = '{4'hF, 4'hF};
        repeat (3) @(negedge clk);
        check("R1", "ev_rd reset", ev_rd, 1'b0);
        check("R1", "ev_wr reset", ev_wr, 1'b0);
        check("R1", "ev_dvc reset", ev_dvc, 1'b0);
        rst_n = 1;
        @(negedge clk);
        sweep();
        // Second configuration: partial byte enables, read-only reg0, write-only reg1 with DVC.
        cmp_rd_en = 2'b01; cmp_wr_en = 2'b10; dvc_en = 2'b11;
        dvc_byte_en = '{4'h0, 4'b0011};
        sweep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        done = 1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule